// File: doc/BRIEF.md
# Eight-Channel Block-Transfer DMA Engine

This engine moves bytes between a 24-bit system address and a register offset in the 0x21xx I/O page. Eight channels each hold a control byte, a page offset, a 24-bit system address and a 16-bit byte count. Software fills these in through a byte-wide register port and then writes a trigger byte. Every channel whose trigger bit is set is served in turn. The lowest-numbered channel goes first, and each channel finishes before the next one begins.

Each byte takes two bus cycles on the master port: a read of the source, then a write of the destination. A three-bit mode sets the unit length and the offset added to the page offset for each byte of the unit. The direction bit picks which side is the source. The system address moves by one step per byte and the count falls by one per byte. Any access on the system side that would reach the engine's own trigger registers is suppressed.

Top module: `dma8_engine`

## Requirements
- R1: Registers reset to zero and `busy` is low. The register port reads back each channel byte at 0x4300+16·n+k and the trigger at 0x420B. The channel bytes are: k=0 control, k=1 page offset, k=2..4 address (low, middle, bank), k=5..6 count (low, high).
- R2: Control bits 2:0 set the unit. For modes 0..7 the unit lengths are 1,2,2,4,4,4,2,4. The per-byte offsets are: mode 1 gives 0,1; modes 3 and 7 give 0,0,1,1; mode 4 gives 0,1,2,3; mode 5 gives 0,1,0,1; the other modes give 0. The page-side address of byte j is 0x002100 | ((page offset + offset[j mod length]) mod 256).
- R3: When control bit 7 is 0, each byte is read from the system address and written to the page-side address. When bit 7 is 1, each byte is read from the page side and written to the system address.
- R4: Control bits 4:3 set the address step: 0 adds one per byte, 2 subtracts one per byte, and 1 or 3 leave the address fixed. Only the low 16 bits of the address change, with wrap-around, and the bank byte is kept.
- R5: The count falls by one per byte and the channel ends when the count reaches zero. A starting count of 0 therefore moves 65536 bytes. After the run the count register reads 0 and the address register holds the stepped value.
- R6: Triggered channels run one at a time in ascending channel order.
- R7: A channel's trigger bit clears when that channel finishes. `busy` is high exactly while any trigger bit is set.
- R8: Each byte takes two cycles: a read strobe cycle, then a write strobe cycle. `busy` rises in the cycle after the trigger write, so a run of N bytes keeps `busy` high for 2·N cycles.
- R9: A system-side access whose low 16 bits are 0x420B or 0x420C never strobes the bus. A blocked read supplies 0 as the data, and a blocked write is dropped.
- R10: Register-port writes are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| busy | output | 1 | A transfer is in progress |
| bus_addr | output | 24 | Master address |
| bus_rd | output | 1 | Master read strobe |
| bus_wr | output | 1 | Master write strobe |
| bus_wdata | output | 8 | Master write data |
| bus_rdata | input | 8 | Master read data, valid in the strobe cycle |

## Verification
The hardest case to reach is the 16-bit count wrap. A starting count of zero must move a full 65536 bytes, and only a run of about 131k cycles shows it. The bench spends most of its cycle budget on one such run and counts every write strobe. The other hard case is the blocked trigger addresses. The bench reaches them by placing a short incrementing window across 0x420B–0x420C, once for each direction, so that a blocked read and a dropped write both appear alongside normal bytes.

// File: rtl/dma8_engine.sv
module dma8_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        busy,
  output logic [23:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata
);
  localparam int NCH = 8;

  logic [7:0]  ctrl [NCH];
  logic [7:0]  boff [NCH];
  logic [23:0] aadr [NCH];
  logic [15:0] cnt  [NCH];
  logic [7:0]  trig;
  logic [1:0]  idx;
  logic        phase;
  logic [7:0]  hold;
  logic [2:0]  cur;

  function automatic logic [7:0] pattern(input logic [2:0] m);
    case (m)
      3'd1:           pattern = 8'h04;
      3'd3, 3'd7:     pattern = 8'h50;
      3'd4:           pattern = 8'hE4;
      3'd5:           pattern = 8'h44;
      default:        pattern = 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] last_idx(input logic [2:0] m);
    case (m)
      3'd0:                last_idx = 2'd0;
      3'd1, 3'd2, 3'd6:    last_idx = 2'd1;
      default:             last_idx = 2'd3;
    endcase
  endfunction

  always_comb begin
    cur = 3'd0;
    for (int i = NCH - 1; i >= 0; i--)
      if (trig[i]) cur = 3'(i);
  end

  wire [7:0]  c      = ctrl[cur];
  wire [7:0]  pv     = pattern(c[2:0]);
  wire [1:0]  off    = pv[{idx, 1'b0} +: 2];
  wire [23:0] b_addr = {16'h0021, boff[cur] + {6'd0, off}};
  wire [23:0] a_addr = aadr[cur];
  wire        a_blk  = (a_addr[15:0] == 16'h420B) || (a_addr[15:0] == 16'h420C);
  wire        dir    = c[7];

  assign busy      = |trig;
  assign bus_rd    = busy && !phase && !(!dir && a_blk);
  assign bus_wr    = busy && phase && !(dir && a_blk);
  assign bus_addr  = (phase ^ dir) ? b_addr : a_addr;
  assign bus_wdata = hold;

  wire       ch_hit = reg_addr[15:7] == 9'h086;
  wire [2:0] rch    = reg_addr[6:4];
  wire [3:0] rby    = reg_addr[3:0];

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == 16'h420B) reg_rdata = trig;
    else if (ch_hit)
      case (rby)
        4'd0: reg_rdata = ctrl[rch];
        4'd1: reg_rdata = boff[rch];
        4'd2: reg_rdata = aadr[rch][7:0];
        4'd3: reg_rdata = aadr[rch][15:8];
        4'd4: reg_rdata = aadr[rch][23:16];
        4'd5: reg_rdata = cnt[rch][7:0];
        4'd6: reg_rdata = cnt[rch][15:8];
        default: reg_rdata = 8'h00;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl[i] <= '0;
        boff[i] <= '0;
        aadr[i] <= '0;
        cnt[i]  <= '0;
      end
      trig  <= '0;
      idx   <= '0;
      phase <= 1'b0;
      hold  <= '0;
    end else if (!busy) begin
      if (reg_wr) begin
        if (reg_addr == 16'h420B) trig <= reg_wdata;
        else if (ch_hit)
          case (rby)
            4'd0: ctrl[rch] <= reg_wdata;
            4'd1: boff[rch] <= reg_wdata;
            4'd2: aadr[rch][7:0]   <= reg_wdata;
            4'd3: aadr[rch][15:8]  <= reg_wdata;
            4'd4: aadr[rch][23:16] <= reg_wdata;
            4'd5: cnt[rch][7:0]    <= reg_wdata;
            4'd6: cnt[rch][15:8]   <= reg_wdata;
            default: ;
          endcase
      end
    end else if (!phase) begin
      hold  <= (!dir && a_blk) ? 8'h00 : bus_rdata;
      phase <= 1'b1;
    end else begin
      phase <= 1'b0;
      case (c[4:3])
        2'd0:    aadr[cur][15:0] <= a_addr[15:0] + 16'd1;
        2'd2:    aadr[cur][15:0] <= a_addr[15:0] - 16'd1;
        default: ;
      endcase
      cnt[cur] <= cnt[cur] - 16'd1;
      if (cnt[cur] == 16'd1) begin
        trig[cur] <= 1'b0;
        idx       <= 2'd0;
      end else begin
        idx <= (idx == last_idx(c[2:0])) ? 2'd0 : idx + 2'd1;
      end
    end
  end
endmodule

module dma8_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [23:0] bus_addr,
  input logic [7:0]  trig
);
  a_r8_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r8_rd_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
  a_r8_wr_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  a_r7_strobe_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> busy);
  a_r9_no_blocked_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> !(bus_addr[15:0] == 16'h420B || bus_addr[15:0] == 16'h420C));
  a_r10_no_new_trigger_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((trig & ~$past(trig)) == 8'h00));
  a_r7_one_clear_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones($past(trig) & ~trig) <= 1);
endmodule

bind dma8_engine dma8_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .trig(trig)
);

// File: tb/dma8_engine_bench.sv
module dma8_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        busy;
  logic [23:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int fails = 0;
  int blk_strobes = 0;

  logic [23:0] la[$], ea[$];
  logic [7:0]  ld[$], ed[$];

  logic [7:0]  mctl [8];
  logic [7:0]  mbo  [8];
  logic [23:0] mad  [8];
  logic [15:0] mcn  [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return 8'(a[7:0] + 8'(a[15:8] * 3) + 8'(a[23:16] * 7)) ^ 8'hA5;
  endfunction

  assign bus_rdata = fmem(bus_addr);

  dma8_engine u_dma8_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always @(posedge clk) begin
    if (bus_wr) begin
      la.push_back(bus_addr);
      ld.push_back(bus_wdata);
    end
    if ((bus_rd || bus_wr) && (bus_addr[15:0] == 16'h420B || bus_addr[15:0] == 16'h420C))
      blk_strobes++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input int ch, input logic [7:0] ctl, input logic [7:0] bo,
                       input logic [23:0] a, input logic [15:0] n);
    logic [15:0] b;
    b = 16'h4300 + 16'(ch * 16);
    wr(b + 0, ctl); wr(b + 1, bo);
    wr(b + 2, a[7:0]); wr(b + 3, a[15:8]); wr(b + 4, a[23:16]);
    wr(b + 5, n[7:0]); wr(b + 6, n[15:8]);
    mctl[ch] = ctl; mbo[ch] = bo; mad[ch] = a; mcn[ch] = n;
  endtask

  function automatic int unit_len(input logic [2:0] m);
    case (m)
      3'd0: return 1;
      3'd1, 3'd2, 3'd6: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [7:0] unit_off(input logic [2:0] m, input int k);
    case (m)
      3'd1: return 8'(k);
      3'd3, 3'd7: return 8'(k / 2);
      3'd4: return 8'(k);
      3'd5: return 8'(k % 2);
      default: return 8'd0;
    endcase
  endfunction

  function automatic int step_of(input logic [7:0] ctl);
    case (ctl[4:3])
      2'd0: return 1;
      2'd2: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] a_at(input int ch, input int j);
    return {mad[ch][23:16], 16'(int'(mad[ch][15:0]) + j * step_of(mctl[ch]))};
  endfunction

  task automatic expect_ch(input int ch);
    int n;
    logic [23:0] a, b;
    bit blk;
    n = (mcn[ch] == 0) ? 65536 : int'(mcn[ch]);
    for (int j = 0; j < n; j++) begin
      a = a_at(ch, j);
      b = 24'h002100 | {16'd0, 8'(mbo[ch] + unit_off(mctl[ch][2:0], j % unit_len(mctl[ch][2:0])))};
      blk = (a[15:0] == 16'h420B) || (a[15:0] == 16'h420C);
      if (!mctl[ch][7]) begin
        ea.push_back(b); ed.push_back(blk ? 8'h00 : fmem(a));
      end else if (!blk) begin
        ea.push_back(a); ed.push_back(fmem(b));
      end
    end
  endtask

  task automatic go(input logic [7:0] mask, output int cyc);
    la.delete(); ld.delete();
    wr(16'h420B, mask);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic compare(input string tag);
    bit ok;
    chk(la.size() == ea.size(), {tag, " write count"}, la.size(), ea.size());
    ok = (la.size() == ea.size());
    if (ok)
      for (int i = 0; i < la.size(); i++)
        if (la[i] !== ea[i] || ld[i] !== ed[i]) begin
          chk(1'b0, {tag, " write"}, {la[i], ld[i]}, {ea[i], ed[i]});
          ok = 0;
          break;
        end
    if (ok) chk(1'b1, tag, 0, 0);
    ea.delete(); ed.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cyc, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    for (int ch = 0; ch < 8; ch++)
      for (int k = 0; k < 7; k++) begin
        rd(16'h4300 + 16'(ch * 16 + k), d);
        if (d != 0) chk(1'b0, "R1 reset value", d, 0);
      end
    rd(16'h420B, d);
    chk(d == 0, "R1 trigger reset", d, 0);
    setup(2, 8'h9B, 8'h3C, 24'hABCDEF, 16'h1234);
    rd(16'h4324, d); chk(d == 8'hAB, "R1 bank readback", d, 8'hAB);
    rd(16'h4326, d); chk(d == 8'h12, "R1 count readback", d, 8'h12);

    for (int dir = 0; dir < 2; dir++)
      for (int m = 0; m < 8; m++) begin
        logic [7:0] ctl;
        ctl = {dir[0], 2'b00, 2'(m % 4), 3'(m)};
        n = 2 * unit_len(3'(m)) + 1;
        setup(m, ctl, 8'hFE, 24'h5AFFFE - 24'(m), 16'(n));
        expect_ch(m);
        go(8'(1 << m), cyc);
        compare($sformatf("R2 R3 R4 mode %0d dir %0d", m, dir));
        chk(cyc == 2 * n, "R8 busy cycles", cyc, 2 * n);
        rd(16'h4305 + 16'(m * 16), d);
        chk(d == 0, "R5 count low zero", d, 0);
        rd(16'h4303 + 16'(m * 16), d);
        chk(d == a_at(m, n)[15:8], "R4 address after run", d, a_at(m, n)[15:8]);
        rd(16'h4304 + 16'(m * 16), d);
        chk(d == 8'h5A, "R4 bank kept", d, 8'h5A);
        rd(16'h420B, d);
        chk(d == 0, "R7 trigger cleared", d, 0);
      end

    setup(7, 8'h04, 8'h10, 24'h010000, 16'd3);
    setup(0, 8'h81, 8'h20, 24'h020100, 16'd2);
    setup(5, 8'h13, 8'h30, 24'h030200, 16'd5);
    expect_ch(0); expect_ch(5); expect_ch(7);
    go(8'hA1, cyc);
    compare("R6 ascending order");
    chk(cyc == 20, "R8 multi-channel cycles", cyc, 20);

    blk_strobes = 0;
    setup(1, 8'h00, 8'h40, 24'h00420A, 16'd4);
    expect_ch(1);
    go(8'h02, cyc);
    compare("R9 blocked read gives zero");
    setup(1, 8'h80, 8'h40, 24'h7F420A, 16'd4);
    expect_ch(1);
    go(8'h02, cyc);
    compare("R9 blocked write dropped");
    chk(blk_strobes == 0, "R9 no strobe on blocked address", blk_strobes, 0);

    setup(3, 8'h08, 8'h55, 24'h040000, 16'd6);
    @(negedge clk);
    reg_addr = 16'h420B; reg_wdata = 8'h08; reg_wr = 1'b1;
    @(negedge clk);
    reg_addr = 16'h4331; reg_wdata = 8'hEE;
    @(negedge clk);
    reg_addr = 16'h420B; reg_wdata = 8'hFF;
    @(negedge clk);
    reg_wr = 1'b0;
    while (busy) @(negedge clk);
    rd(16'h4331, d);
    chk(d == 8'h55, "R10 offset write ignored while busy", d, 8'h55);
    rd(16'h420B, d);
    chk(d == 0, "R10 trigger write ignored while busy", d, 0);

    setup(4, 8'h08, 8'h00, 24'h060000, 16'd0);
    go(8'h10, cyc);
    chk(la.size() == 65536, "R5 zero count moves 65536 bytes", la.size(), 65536);
    chk(cyc == 131072, "R5 R8 zero count cycles", cyc, 131072);
    rd(16'h4346, d);
    chk(d == 0, "R5 count high zero", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule